// File: doc/BRIEF.md
# Bidirectional GPIO Port Bank

This block provides a bank of general-purpose I/O ports, four by default, each eight pins wide. Every port holds a direction register and an output-data register that the CPU writes over a small register bus. It also has an input register, which is read-only and shows the pad levels after they pass through a two-flop synchroniser. For each pin the block drives three controls towards an external pad cell: an output enable, an output level and a pull-up enable. It receives one raw input back from that pad.

The data register serves two purposes. When a pin is set as an output, the data bit gives the level the pin drives. When a pin is set as an input, the same bit switches that pin's pull-up on or off. Software selects a port and a register, then writes a byte with a one-cycle strobe. Reads are combinational from the current select lines.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, every direction and data bit is 0. All pad output enables, output levels and pull-up enables are therefore 0, and reads of the direction and data registers return 0x00.
- R2: A write with register select 1 loads the direction register of the selected port. From the next clock, each pin's output enable equals its direction bit, where 1 means output and 0 means input.
- R3: A write with register select 2 loads the data register of the selected port. From the next clock, each pin's output level equals its data bit.
- R4: A pin's pull-up enable is 1 exactly when its data bit is 1 and its direction bit is 0.
- R5: A read with register select 0 returns the pad input level of the selected port as it was two clock edges earlier, delayed by a two-flop synchroniser.
- R6: Reads are combinational. Register select 1 returns the direction register, select 2 returns the data register, and select 3 returns 0x00.
- R7: A write with register select 0 or 3 changes no register. No pad control of any port changes because of it.
- R8: A write changes only the port named by the port select. All other ports keep their registers and pad controls.
- R9: When a pin is an output, reading the input register returns the synchronised pad level, not the data register bit.
- R10: Writing 0xFF to a port's direction register makes all eight pins outputs, and no pull-up of that port stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_port_sel | input | 2 | Port select (0..3) |
| bus_reg_sel | input | 2 | Register select: 0 input, 1 direction, 2 data, 3 none |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 32 | Raw pad inputs, port p in bits [8p+7:8p] |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output level |
| pad_pu | output | 32 | Per-pin pull-up enable |

## Verification
Several behaviours are checked by assertions on every cycle: a direction or data write appears on the pad controls one clock later, writes to the input or unused address leave the pad controls unchanged, and the synchroniser output always equals the raw pad level from two edges earlier. Some behaviours can only be shown by the bench's scenarios. These are the isolation between ports, the dual role of the data bit as level or pull-up across mixed direction patterns, and reads of the input register on output pins that the pad is pulling away from the driven value. The bench shows them with directed cases and a long random mix compared against a reference model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        REG_IN   = 2'd0,
        REG_DIR  = 2'd1,
        REG_DAT  = 2'd2,
        REG_NONE = 2'd3
    } gpio_reg_e;

    typedef struct packed {
        logic oe;
        logic lvl;
        logic pu;
    } pad_ctl_t;

    function automatic pad_ctl_t pad_ctl(input logic dir_bit, input logic dat_bit);
        pad_ctl_t c;
        c.oe  = dir_bit;
        c.lvl = dat_bit;
        c.pu  = dat_bit & ~dir_bit;
        return c;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw;
            stage2_q <= stage1_q;
        end
    end

    assign synced = stage2_q;

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R5
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (synced == $past(raw, 2)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  gpio_reg_e    reg_sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] rdata,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    logic [W-1:0] dir_q;
    logic [W-1:0] dat_q;
    logic [W-1:0] in_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (wr_en) begin
            case (reg_sel)
                REG_DIR: dir_q <= wdata;
                REG_DAT: dat_q <= wdata;
                default: ;
            endcase
        end
    end

    gpio_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pad_in),
        .synced (in_sync)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        pad_ctl_t ctl;
        assign ctl        = pad_ctl(dir_q[i], dat_q[i]);
        assign pad_oe[i]  = ctl.oe;
        assign pad_out[i] = ctl.lvl;
        assign pad_pu[i]  = ctl.pu;
    end

    always_comb begin
        case (reg_sel)
            REG_IN:  rdata = in_sync;
            REG_DIR: rdata = dir_q;
            REG_DAT: rdata = dat_q;
            default: rdata = '0;
        endcase
    end

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == REG_DIR) |=> (pad_oe == $past(wdata)));

    // R3
    dat_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == REG_DAT) |=> (pad_out == $past(wdata)));

    // R7
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (reg_sel == REG_IN || reg_sel == REG_NONE))
        |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int TOT_W    = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [SEL_W-1:0]  bus_port_sel,
    input  logic [1:0]        bus_reg_sel,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [TOT_W-1:0]  pad_in,
    output logic [TOT_W-1:0]  pad_oe,
    output logic [TOT_W-1:0]  pad_out,
    output logic [TOT_W-1:0]  pad_pu
);
    gpio_reg_e         reg_sel;
    logic [PORT_W-1:0] port_rd [NUM_PORTS];

    assign reg_sel = gpio_reg_e'(bus_reg_sel);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = bus_we && (bus_port_sel == SEL_W'(p));

        gpio_port #(.W(PORT_W)) u_port (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (hit),
            .reg_sel (reg_sel),
            .wdata   (bus_wdata),
            .pad_in  (pad_in [p*PORT_W +: PORT_W]),
            .rdata   (port_rd[p]),
            .pad_oe  (pad_oe [p*PORT_W +: PORT_W]),
            .pad_out (pad_out[p*PORT_W +: PORT_W]),
            .pad_pu  (pad_pu [p*PORT_W +: PORT_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_port_sel == SEL_W'(p)) bus_rdata = port_rd[p];
        end
    end

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_we;
    logic [1:0]    bus_port_sel;
    logic [1:0]    bus_reg_sel;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata;
    logic [31:0]   pad_in;
    logic [31:0]   pad_oe, pad_out, pad_pu;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] dir_m [NP];
    logic [7:0] dat_m [NP];
    logic [7:0] s1_m  [NP];
    logic [7:0] s2_m  [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_port_sel(bus_port_sel),
        .bus_reg_sel(bus_reg_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int p, input int r);
        case (r)
            0: return s2_m[p];
            1: return dir_m[p];
            2: return dat_m[p];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            dir_m[p] = 0; dat_m[p] = 0; s1_m[p] = 0; s2_m[p] = 0;
        end
    endtask

    // One clock: model update at the edge, pad checks at the following negedge
    task automatic cyc();
        @(posedge clk);
        for (int p = 0; p < NP; p++) begin
            s2_m[p] = s1_m[p];
            s1_m[p] = pad_in[p*W +: W];
        end
        if (bus_we && bus_reg_sel == 2'd1) dir_m[bus_port_sel] = bus_wdata;
        if (bus_we && bus_reg_sel == 2'd2) dat_m[bus_port_sel] = bus_wdata;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_pads(input string tag);
        logic [31:0] eoe, eout, epu;
        for (int p = 0; p < NP; p++) begin
            eoe [p*W +: W] = dir_m[p];
            eout[p*W +: W] = dat_m[p];
            epu [p*W +: W] = dat_m[p] & ~dir_m[p];
        end
        check({tag, " R2 oe"}, pad_oe, eoe);
        check({tag, " R3 out"}, pad_out, eout);
        check({tag, " R4 pu"}, pad_pu, epu);
    endtask

    task automatic wr(input int p, input int r, input logic [7:0] d);
        bus_we = 1'b1; bus_port_sel = 2'(p); bus_reg_sel = 2'(r); bus_wdata = d;
        cyc();
    endtask

    task automatic rd_check(input string tag, input int p, input int r);
        bus_port_sel = 2'(p); bus_reg_sel = 2'(r);
        #1;
        check(tag, {24'h0, bus_rdata}, {24'h0, exp_read(p, r)});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; bus_we = 0; bus_port_sel = 0; bus_reg_sel = 0; bus_wdata = 0; pad_in = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 oe", pad_oe, 32'h0);
        check("R1 out", pad_out, 32'h0);
        check("R1 pu", pad_pu, 32'h0);
        rd_check("R1 dir read", 1, 1);
        rd_check("R1 dat read", 3, 2);

        // R10 all outputs
        wr(0, 1, 8'hFF);
        check("R10 oe", {24'h0, pad_oe[7:0]}, 32'hFF);
        check("R10 pu", {24'h0, pad_pu[7:0]}, 32'h00);
        // R3 level
        wr(0, 2, 8'h5A);
        check("R3 level", {24'h0, pad_out[7:0]}, 32'h5A);
        check("R10 pu after data", {24'h0, pad_pu[7:0]}, 32'h00);
        // R9 / R5 input on output pins differs from data
        pad_in[7:0] = 8'hA5;
        cyc();
        rd_check("R5 one edge", 0, 0);
        cyc();
        rd_check("R9 input read", 0, 0);
        check("R9 value", {24'h0, bus_rdata}, 32'hA5);
        // R7 ignored writes
        wr(0, 0, 8'h00);
        check_pads("R7 in-addr");
        wr(0, 3, 8'h00);
        check_pads("R7 none-addr");
        rd_check("R6 addr3", 0, 3);
        // R8 isolation
        wr(2, 1, 8'h0F);
        check("R8 port0 kept", {24'h0, pad_oe[7:0]}, 32'hFF);
        check("R8 port2", {24'h0, pad_oe[23:16]}, 32'h0F);
        // R4 pull-ups on inputs
        wr(1, 2, 8'hC3);
        check("R4 pu", {24'h0, pad_pu[15:8]}, 32'hC3);
        wr(1, 1, 8'h81);
        check("R4 pu mixed", {24'h0, pad_pu[15:8]}, 32'h42);
        check_pads("directed");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            int p;
            r = $urandom_range(0, 3);
            p = $urandom_range(0, 3);
            if ($urandom_range(0, 3) != 0) pad_in = $urandom;
            rd_check(r == 0 ? "R5 rand read" : "R6 rand read", p, r);
            bus_we = ($urandom_range(0, 1) == 1);
            bus_port_sel = 2'($urandom_range(0, 3));
            bus_reg_sel = 2'($urandom_range(0, 3));
            bus_wdata = 8'($urandom);
            cyc();
            check_pads("R8 rand");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule